// File: doc/BRIEF.md
# Processor Power Mode Controller

This block is the synchronous sequencer that moves a processor between five power modes: full-on, active, sleep, deep sleep and hibernate. From the current mode it drives the enables for the PLL, the PLL bypass, the core clock, the system clock and the internal supply. It also drives the pin three-state control, the SDRAM clock-enable-low request, the permission for DMA into L1 memory and a mode status code. The PLL, clock gates, regulator, RTC and DMA engine sit outside and only consume these controls.

Software asks for a mode change with a 3-bit request code and a strobe. It writes PLL settings (enable, bypass and a multiplier) and regulator settings (frequency field and an SDRAM hold bit) through write strobes. These writes are taken only while the core runs, in full-on or active. The multiplier is staged and reaches the PLL only when full-on is entered. Hibernate is entered by writing 00 to the regulator frequency field. Each low-power mode has its own set of wake inputs, and the mode it returns to depends on which input fired.

Leaving hibernate runs a hardware reset sequence that lasts a parameterised number of cycles. During it the clocks stay gated and the pins stay three-stated. At its end the block is in full-on with every controller register back at its default, except the regulator settings.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After rst_n the mode code is 0 (full-on), the applied multiplier equals MULT_DEF, the error flag is 0 and full-on outputs are driven.
- R2: Outputs per mode (mode_o code). Full-on (0): pll on, bypass 0, cclk 1, sclk 1, supply 1. Active (1): pll_en follows the PLL enable register, bypass 1, cclk 1, sclk 1, supply 1. Sleep (2): pll on, bypass follows the bypass register, cclk 0, sclk 1, supply 1. Deep sleep (3): pll 0, bypass 0, cclk 0, sclk 0, supply 1. Hibernate (4): all of these 0 and pins three-stated. Pins are three-stated only in codes 4 and 5.
- R3: Requests are taken only in full-on or active, with code 0 = full-on, 1 = active, 2 = sleep, 3 = deep sleep. Codes 4 to 7 leave the mode unchanged and set the error flag. In any other mode a request strobe changes neither the mode nor the flag.
- R4: The PLL enable register is written only in active mode; a write of it in full-on is dropped. While it is 0, requests for full-on or sleep leave the mode unchanged and set the error flag.
- R5: A multiplier written in full-on or active is staged. pll_mult_o takes the staged value, as held before that cycle, only on a transition into full-on.
- R6: In sleep, wake_gen leads to active if the bypass register is 1 and to full-on if it is 0. wake_rtc, wake_eth and wake_can are ignored there.
- R7: In deep sleep, wake_rtc leads to active and wake_rst leads to full-on. wake_gen, wake_eth, wake_can and request strobes are ignored.
- R8: A regulator write with frequency field 00, made in full-on or active, enters hibernate on the next edge and wins over a request strobe in the same cycle. Other field values do not change the mode.
- R9: In hibernate, wake_eth, wake_can, wake_rtc or wake_rst starts the reset sequence (code 5) and wake_gen is ignored. The sequence lasts RST_CYC cycles with both clocks gated, supply on and pins three-stated, then full-on follows. PLL registers, the staged and applied multiplier and the error flag return to defaults.
- R10: sdram_cke_low_o equals the SDRAM hold bit in hibernate and in the reset sequence, and is 0 otherwise. The hold bit survives the reset sequence.
- R11: dma_l1_ok_o is 1 in full-on and active only.
- R12: The error flag is sticky and err_clr clears it. When err_clr and a new error come in the same cycle, the flag ends up set.
- R13: wake_rst in full-on, active, sleep or deep sleep gives full-on on the next edge. It returns the PLL registers, the multiplier and the error flag to defaults and keeps the regulator settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| req_vld | input | 1 | Mode request strobe |
| req_code | input | 3 | Requested mode code |
| err_clr | input | 1 | Clears the sticky error flag |
| ctl_wr | input | 1 | PLL settings write strobe |
| ctl_pll_en | input | 1 | PLL enable value to write |
| ctl_bypass | input | 1 | Bypass value to write |
| ctl_mult | input | MULT_W | Multiplier value to stage |
| vr_wr | input | 1 | Regulator settings write strobe |
| vr_freq | input | 2 | Regulator frequency field; 00 enters hibernate |
| vr_sdram_hold | input | 1 | SDRAM hold bit to write |
| wake_gen | input | 1 | Generic wakeup |
| wake_rtc | input | 1 | RTC interrupt or wake |
| wake_eth | input | 1 | Ethernet wake |
| wake_can | input | 1 | CAN wake |
| wake_rst | input | 1 | Reset pin event, synchronous |
| pll_en_o | output | 1 | PLL enable |
| pll_bypass_o | output | 1 | PLL bypass |
| pll_mult_o | output | MULT_W | Multiplier applied to the PLL |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| vdd_int_en_o | output | 1 | Internal supply enable |
| pin_tristate_o | output | 1 | External pins three-state |
| sdram_cke_low_o | output | 1 | Hold SDRAM clock enable low |
| dma_l1_ok_o | output | 1 | DMA into L1 permitted |
| mode_o | output | 3 | Current mode code |
| req_err_o | output | 1 | Sticky error flag |

## Verification
Several patterns of request and wake traffic are driven, and a behavioural model checks every output on every cycle. Sleep is woken once with bypass set and once with it clear, so a fixed wake target would be caught. Each low-power mode is also given the wake inputs it must ignore, which separates the per-mode wake tables from a shared one. Multiplier writes are made in active, in full-on and before hibernate, which tells staged application apart from a direct write and from a value that wrongly survives the reset sequence. The refused and undefined requests, the hibernate write raced against a request, and a clear raced against a new error show the priority rules.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      MD_FULL   = 3'd0,
      MD_ACTIVE = 3'd1,
      MD_SLEEP  = 3'd2,
      MD_DEEP   = 3'd3,
      MD_HIBER  = 3'd4,
      MD_RSTSEQ = 3'd5
   } pwr_mode_e;

   localparam logic [2:0] RQ_FULL   = 3'd0;
   localparam logic [2:0] RQ_ACTIVE = 3'd1;
   localparam logic [2:0] RQ_SLEEP  = 3'd2;
   localparam logic [2:0] RQ_DEEP   = 3'd3;

   localparam logic [1:0] VR_OFF = 2'b00;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int RST_CYC = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req_vld,
   input  logic [2:0] req_code,
   input  logic      vr_wr,
   input  logic [1:0] vr_freq,
   input  logic      err_clr,
   input  logic      wake_gen,
   input  logic      wake_rtc,
   input  logic      wake_eth,
   input  logic      wake_can,
   input  logic      wake_rst,
   input  logic      pll_en_q,
   input  logic      pll_byp_q,
   output pwr_mode_e mode_q,
   output logic      soft_rst,
   output logic      enter_full,
   output logic      cfg_acc,
   output logic      err_q
);

   localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

   pwr_mode_e nxt;
   logic      bad_req;
   logic      seq_done;
   logic      hib_wake;

   assign hib_wake = wake_eth | wake_can | wake_rtc | wake_rst;

   always_comb begin
      nxt      = mode_q;
      soft_rst = 1'b0;
      bad_req  = 1'b0;
      cfg_acc  = 1'b0;
      case (mode_q)
         MD_FULL, MD_ACTIVE: begin
            if (wake_rst) begin
               nxt      = MD_FULL;
               soft_rst = 1'b1;
            end else begin
               cfg_acc = 1'b1;
               if (vr_wr && vr_freq == VR_OFF) begin
                  nxt = MD_HIBER;
               end else if (req_vld) begin
                  case (req_code)
                     RQ_FULL: begin
                        if (pll_en_q) nxt = MD_FULL;
                        else          bad_req = 1'b1;
                     end
                     RQ_ACTIVE: nxt = MD_ACTIVE;
                     RQ_SLEEP: begin
                        if (pll_en_q) nxt = MD_SLEEP;
                        else          bad_req = 1'b1;
                     end
                     RQ_DEEP: nxt = MD_DEEP;
                     default: bad_req = 1'b1;
                  endcase
               end
            end
         end
         MD_SLEEP: begin
            if (wake_rst) begin
               nxt      = MD_FULL;
               soft_rst = 1'b1;
            end else if (wake_gen) begin
               nxt = pll_byp_q ? MD_ACTIVE : MD_FULL;
            end
         end
         MD_DEEP: begin
            if (wake_rst) begin
               nxt      = MD_FULL;
               soft_rst = 1'b1;
            end else if (wake_rtc) begin
               nxt = MD_ACTIVE;
            end
         end
         MD_HIBER: begin
            if (hib_wake) begin
               nxt      = MD_RSTSEQ;
               soft_rst = 1'b1;
            end
         end
         MD_RSTSEQ: begin
            if (seq_done) nxt = MD_FULL;
         end
         default: nxt = MD_FULL;
      endcase
   end

   assign enter_full = (nxt == MD_FULL) && (mode_q != MD_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MD_FULL;
      else        mode_q <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_q <= 1'b0;
      else if (soft_rst) err_q <= 1'b0;
      else if (bad_req)  err_q <= 1'b1;
      else if (err_clr)  err_q <= 1'b0;
   end

   generate
      if (RST_CYC == 1) begin : g_seq_one
         assign seq_done = 1'b1;
      end else begin : g_seq_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q <= '0;
            else if (mode_q != MD_RSTSEQ) cnt_q <= '0;
            else if (!seq_done)          cnt_q <= cnt_q + 1'b1;
         end
         assign seq_done = (cnt_q == CNT_W'(RST_CYC - 1));
      end
   endgenerate

   // R3
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q inside {MD_FULL, MD_ACTIVE, MD_SLEEP, MD_DEEP, MD_HIBER, MD_RSTSEQ});

   // R7
   deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_DEEP && !wake_rtc && !wake_rst) |=> (mode_q == MD_DEEP));

   // R6
   sleep_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_SLEEP && wake_gen && !wake_rst)
      |=> (mode_q == ($past(pll_byp_q) ? MD_ACTIVE : MD_FULL)));

   // R9
   hib_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_HIBER && hib_wake) |=> (mode_q == MD_RSTSEQ));

   // R4
   pll_off_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_ACTIVE && !wake_rst && !vr_wr && req_vld && !pll_en_q &&
       (req_code == RQ_FULL || req_code == RQ_SLEEP))
      |=> (mode_q == MD_ACTIVE && err_q));

   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !err_clr && !soft_rst) |=> err_q);

   // R13
   rst_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_rst && mode_q != MD_HIBER && mode_q != MD_RSTSEQ) |=> (mode_q == MD_FULL));

endmodule

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs #(
   parameter int MULT_W   = 6,
   parameter int MULT_DEF = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_acc,
   input  logic              soft_rst,
   input  logic              enter_full,
   input  logic              is_active,
   input  logic              ctl_wr,
   input  logic              ctl_pll_en,
   input  logic              ctl_bypass,
   input  logic [MULT_W-1:0] ctl_mult,
   input  logic              vr_wr,
   input  logic              vr_sdram_hold,
   output logic              pll_en_q,
   output logic              pll_byp_q,
   output logic [MULT_W-1:0] mult_app_q,
   output logic              hold_q
);

   localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(MULT_DEF);

   logic [MULT_W-1:0] mult_stg_q;
   logic              ctl_take;

   assign ctl_take = cfg_acc & ctl_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_en_q   <= 1'b1;
         pll_byp_q  <= 1'b0;
         mult_stg_q <= MULT_RST;
      end else if (soft_rst) begin
         pll_en_q   <= 1'b1;
         pll_byp_q  <= 1'b0;
         mult_stg_q <= MULT_RST;
      end else if (ctl_take) begin
         if (is_active) pll_en_q <= ctl_pll_en;
         pll_byp_q  <= ctl_bypass;
         mult_stg_q <= ctl_mult;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mult_app_q <= MULT_RST;
      else if (soft_rst)   mult_app_q <= MULT_RST;
      else if (enter_full) mult_app_q <= mult_stg_q;
   end

   // regulator settings survive the soft reset that ends hibernate
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold_q <= 1'b0;
      else if (cfg_acc && vr_wr) hold_q <= vr_sdram_hold;
   end

   // R5
   mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enter_full && !soft_rst) |=> $stable(mult_app_q));

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import pwr_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pwr_mode_e mode_q,
   input  logic      pll_en_q,
   input  logic      pll_byp_q,
   input  logic      hold_q,
   output logic      pll_en_o,
   output logic      pll_bypass_o,
   output logic      cclk_en_o,
   output logic      sclk_en_o,
   output logic      vdd_int_en_o,
   output logic      pin_tristate_o,
   output logic      sdram_cke_low_o,
   output logic      dma_l1_ok_o
);

   always_comb begin
      pll_en_o        = 1'b0;
      pll_bypass_o    = 1'b0;
      cclk_en_o       = 1'b0;
      sclk_en_o       = 1'b0;
      vdd_int_en_o    = 1'b1;
      pin_tristate_o  = 1'b0;
      sdram_cke_low_o = 1'b0;
      dma_l1_ok_o     = 1'b0;
      case (mode_q)
         MD_FULL: begin
            pll_en_o    = 1'b1;
            cclk_en_o   = 1'b1;
            sclk_en_o   = 1'b1;
            dma_l1_ok_o = 1'b1;
         end
         MD_ACTIVE: begin
            pll_en_o     = pll_en_q;
            pll_bypass_o = 1'b1;
            cclk_en_o    = 1'b1;
            sclk_en_o    = 1'b1;
            dma_l1_ok_o  = 1'b1;
         end
         MD_SLEEP: begin
            pll_en_o     = 1'b1;
            pll_bypass_o = pll_byp_q;
            sclk_en_o    = 1'b1;
         end
         MD_DEEP: begin
         end
         MD_HIBER: begin
            vdd_int_en_o    = 1'b0;
            pin_tristate_o  = 1'b1;
            sdram_cke_low_o = hold_q;
         end
         MD_RSTSEQ: begin
            pin_tristate_o  = 1'b1;
            sdram_cke_low_o = hold_q;
         end
         default: begin
         end
      endcase
   end

   // R2
   clk_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cclk_en_o |-> sclk_en_o);

   // R9
   supply_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vdd_int_en_o |-> pin_tristate_o);

   // R11
   dma_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_l1_ok_o |-> cclk_en_o);

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
   import pwr_mode_pkg::*;
#(
   parameter int MULT_W   = 6,
   parameter int MULT_DEF = 10,
   parameter int RST_CYC  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [2:0]        req_code,
   input  logic              err_clr,
   input  logic              ctl_wr,
   input  logic              ctl_pll_en,
   input  logic              ctl_bypass,
   input  logic [MULT_W-1:0] ctl_mult,
   input  logic              vr_wr,
   input  logic [1:0]        vr_freq,
   input  logic              vr_sdram_hold,
   input  logic              wake_gen,
   input  logic              wake_rtc,
   input  logic              wake_eth,
   input  logic              wake_can,
   input  logic              wake_rst,
   output logic              pll_en_o,
   output logic              pll_bypass_o,
   output logic [MULT_W-1:0] pll_mult_o,
   output logic              cclk_en_o,
   output logic              sclk_en_o,
   output logic              vdd_int_en_o,
   output logic              pin_tristate_o,
   output logic              sdram_cke_low_o,
   output logic              dma_l1_ok_o,
   output logic [2:0]        mode_o,
   output logic              req_err_o
);

   if (MULT_W < 1) begin : g_bad_mult_w
      $error("MULT_W must be at least 1");
   end
   if (MULT_DEF < 0 || MULT_DEF >= (1 << MULT_W)) begin : g_bad_mult_def
      $error("MULT_DEF must fit in MULT_W bits");
   end
   if (RST_CYC < 1) begin : g_bad_rst_cyc
      $error("RST_CYC must be at least 1");
   end

   pwr_mode_e mode_q;
   logic      soft_rst;
   logic      enter_full;
   logic      cfg_acc;
   logic      pll_en_q;
   logic      pll_byp_q;
   logic      hold_q;

   pwr_mode_fsm #(.RST_CYC(RST_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (req_vld),
      .req_code   (req_code),
      .vr_wr      (vr_wr),
      .vr_freq    (vr_freq),
      .err_clr    (err_clr),
      .wake_gen   (wake_gen),
      .wake_rtc   (wake_rtc),
      .wake_eth   (wake_eth),
      .wake_can   (wake_can),
      .wake_rst   (wake_rst),
      .pll_en_q   (pll_en_q),
      .pll_byp_q  (pll_byp_q),
      .mode_q     (mode_q),
      .soft_rst   (soft_rst),
      .enter_full (enter_full),
      .cfg_acc    (cfg_acc),
      .err_q      (req_err_o)
   );

   pwr_cfg_regs #(.MULT_W(MULT_W), .MULT_DEF(MULT_DEF)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_acc       (cfg_acc),
      .soft_rst      (soft_rst),
      .enter_full    (enter_full),
      .is_active     (mode_q == MD_ACTIVE),
      .ctl_wr        (ctl_wr),
      .ctl_pll_en    (ctl_pll_en),
      .ctl_bypass    (ctl_bypass),
      .ctl_mult      (ctl_mult),
      .vr_wr         (vr_wr),
      .vr_sdram_hold (vr_sdram_hold),
      .pll_en_q      (pll_en_q),
      .pll_byp_q     (pll_byp_q),
      .mult_app_q    (pll_mult_o),
      .hold_q        (hold_q)
   );

   pwr_out_decode u_dec (
      .clk             (clk),
      .rst_n           (rst_n),
      .mode_q          (mode_q),
      .pll_en_q        (pll_en_q),
      .pll_byp_q       (pll_byp_q),
      .hold_q          (hold_q),
      .pll_en_o        (pll_en_o),
      .pll_bypass_o    (pll_bypass_o),
      .cclk_en_o       (cclk_en_o),
      .sclk_en_o       (sclk_en_o),
      .vdd_int_en_o    (vdd_int_en_o),
      .pin_tristate_o  (pin_tristate_o),
      .sdram_cke_low_o (sdram_cke_low_o),
      .dma_l1_ok_o     (dma_l1_ok_o)
   );

   assign mode_o = mode_q;

   // R1
   full_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_FULL) |-> (pll_en_o && !pll_bypass_o && vdd_int_en_o));

   // R10
   cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sdram_cke_low_o |-> pin_tristate_o);

endmodule

// File: tb/pwr_mode_ctl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;
   localparam int MW = 6;
   localparam int MD = 10;
   localparam int RC = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, req_vld, err_clr, ctl_wr, ctl_pll_en, ctl_bypass, vr_wr, vr_sdram_hold;
   logic [2:0] req_code;
   logic [MW-1:0] ctl_mult;
   logic [1:0] vr_freq;
   logic wake_gen, wake_rtc, wake_eth, wake_can, wake_rst;
   logic pll_en_o, pll_bypass_o, cclk_en_o, sclk_en_o, vdd_int_en_o;
   logic pin_tristate_o, sdram_cke_low_o, dma_l1_ok_o, req_err_o;
   logic [MW-1:0] pll_mult_o;
   logic [2:0] mode_o;

   pwr_mode_ctl #(.MULT_W(MW), .MULT_DEF(MD), .RST_CYC(RC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_code(req_code), .err_clr(err_clr),
      .ctl_wr(ctl_wr), .ctl_pll_en(ctl_pll_en), .ctl_bypass(ctl_bypass), .ctl_mult(ctl_mult),
      .vr_wr(vr_wr), .vr_freq(vr_freq), .vr_sdram_hold(vr_sdram_hold),
      .wake_gen(wake_gen), .wake_rtc(wake_rtc), .wake_eth(wake_eth), .wake_can(wake_can),
      .wake_rst(wake_rst), .pll_en_o(pll_en_o), .pll_bypass_o(pll_bypass_o),
      .pll_mult_o(pll_mult_o), .cclk_en_o(cclk_en_o), .sclk_en_o(sclk_en_o),
      .vdd_int_en_o(vdd_int_en_o), .pin_tristate_o(pin_tristate_o),
      .sdram_cke_low_o(sdram_cke_low_o), .dma_l1_ok_o(dma_l1_ok_o),
      .mode_o(mode_o), .req_err_o(req_err_o)
   );

   int total = 0;
   int bad = 0;
   string cur_tag = "R1";

   task automatic chk(string tag, int got, int exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
      end
   endtask

   // behavioural reference model
   int m_mode, m_stg, m_app, m_cnt;
   bit m_pen, m_byp, m_hold, m_err;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_pen = 1; m_byp = 0; m_stg = MD; m_app = MD;
         m_hold = 0; m_err = 0; m_cnt = 0;
      end else begin
         int nm;
         bit dflt, seterr;
         bit old_pen;
         int old_stg;
         nm = m_mode; dflt = 0; seterr = 0;
         old_pen = m_pen; old_stg = m_stg;
         if (m_mode == 0 || m_mode == 1) begin
            if (wake_rst) begin nm = 0; dflt = 1; end
            else begin
               if (ctl_wr) begin
                  if (m_mode == 1) m_pen = ctl_pll_en;
                  m_byp = ctl_bypass; m_stg = ctl_mult;
               end
               if (vr_wr) m_hold = vr_sdram_hold;
               if (vr_wr && vr_freq == 2'b00) nm = 4;
               else if (req_vld) begin
                  if (req_code == 0) begin if (old_pen) nm = 0; else seterr = 1; end
                  else if (req_code == 1) nm = 1;
                  else if (req_code == 2) begin if (old_pen) nm = 2; else seterr = 1; end
                  else if (req_code == 3) nm = 3;
                  else seterr = 1;
               end
            end
         end else if (m_mode == 2) begin
            if (wake_rst) begin nm = 0; dflt = 1; end
            else if (wake_gen) nm = m_byp ? 1 : 0;
         end else if (m_mode == 3) begin
            if (wake_rst) begin nm = 0; dflt = 1; end
            else if (wake_rtc) nm = 1;
         end else if (m_mode == 4) begin
            if (wake_rst || wake_eth || wake_can || wake_rtc) begin nm = 5; dflt = 1; m_cnt = 0; end
         end else begin
            if (m_cnt == RC - 1) nm = 0; else m_cnt++;
         end
         if (dflt) begin
            m_pen = 1; m_byp = 0; m_stg = MD; m_app = MD; m_err = 0;
         end else begin
            if (nm == 0 && m_mode != 0) m_app = old_stg;
            if (seterr) m_err = 1;
            else if (err_clr) m_err = 0;
         end
         m_mode = nm;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int m;
         m = m_mode;
         chk({cur_tag, " mode"}, mode_o, m);
         chk({cur_tag, " pll_en"}, pll_en_o, int'(m == 0 || m == 2 || (m == 1 && m_pen)));
         chk({cur_tag, " bypass"}, pll_bypass_o, (m == 1) ? 1 : (m == 2) ? int'(m_byp) : 0);
         chk({cur_tag, " mult"}, pll_mult_o, m_app);
         chk({cur_tag, " cclk"}, cclk_en_o, int'(m <= 1));
         chk({cur_tag, " sclk"}, sclk_en_o, int'(m <= 2));
         chk({cur_tag, " vdd"}, vdd_int_en_o, int'(m != 4));
         chk({cur_tag, " tri"}, pin_tristate_o, int'(m >= 4));
         chk({cur_tag, " cke_low"}, sdram_cke_low_o, int'(m_hold && m >= 4));
         chk({cur_tag, " dma"}, dma_l1_ok_o, int'(m <= 1));
         chk({cur_tag, " err"}, req_err_o, int'(m_err));
      end
   end

   task automatic go();
      @(posedge clk);
      #1;
      req_vld = 0; err_clr = 0; ctl_wr = 0; vr_wr = 0;
      wake_gen = 0; wake_rtc = 0; wake_eth = 0; wake_can = 0; wake_rst = 0;
      @(negedge clk);
   endtask

   task automatic req(int code);
      req_vld = 1; req_code = 3'(code);
      go();
   endtask

   task automatic ctl(bit pen, bit byp, int mult);
      ctl_wr = 1; ctl_pll_en = pen; ctl_bypass = byp; ctl_mult = MW'(mult);
      go();
   endtask

   task automatic seq_len(string tag);
      int n;
      n = 0;
      while (mode_o == 3'd5 && n < 100) begin
         n++;
         @(negedge clk);
      end
      chk(tag, n, RC);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 0; req_vld = 0; req_code = 0; err_clr = 0; ctl_wr = 0; ctl_pll_en = 0;
      ctl_bypass = 0; ctl_mult = 0; vr_wr = 0; vr_freq = 2'b11; vr_sdram_hold = 0;
      wake_gen = 0; wake_rtc = 0; wake_eth = 0; wake_can = 0; wake_rst = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      cur_tag = "R1";
      chk("R1 reset mode", mode_o, 0);
      chk("R1 reset mult", pll_mult_o, MD);
      chk("R1 reset err", req_err_o, 0);
      chk("R1 reset cclk", cclk_en_o, 1);

      cur_tag = "R3";
      req(1);
      chk("R3 to active", mode_o, 1);
      chk("R2 active bypass", pll_bypass_o, 1);
      chk("R11 active dma", dma_l1_ok_o, 1);

      cur_tag = "R5";
      ctl(1, 1, 23);
      chk("R5 staged not applied", pll_mult_o, MD);
      req(0);
      chk("R3 to full", mode_o, 0);
      chk("R5 applied on full entry", pll_mult_o, 23);
      ctl(0, 1, 40);
      chk("R5 write in full held", pll_mult_o, 23);

      cur_tag = "R12";
      req(6);
      chk("R3 undefined code mode", mode_o, 0);
      chk("R12 undefined sets err", req_err_o, 1);
      err_clr = 1;
      req(7);
      chk("R12 set wins over clear", req_err_o, 1);
      err_clr = 1;
      go();
      chk("R12 clear", req_err_o, 0);

      cur_tag = "R6";
      req(2);
      chk("R4 pll_en write in full ignored, sleep taken", mode_o, 2);
      chk("R2 sleep cclk", cclk_en_o, 0);
      chk("R11 sleep dma", dma_l1_ok_o, 0);
      req(3);
      chk("R3 request in sleep ignored", mode_o, 2);
      chk("R3 request in sleep no err", req_err_o, 0);
      wake_eth = 1; wake_rtc = 1; wake_can = 1;
      go();
      chk("R6 other wakes ignored", mode_o, 2);
      wake_gen = 1;
      go();
      chk("R6 bypass set goes active", mode_o, 1);

      cur_tag = "R4";
      ctl(0, 0, 40);
      chk("R4 pll off in active", pll_en_o, 0);
      req(0);
      chk("R4 full refused mode", mode_o, 1);
      chk("R4 full refused err", req_err_o, 1);
      err_clr = 1;
      go();
      req(2);
      chk("R4 sleep refused mode", mode_o, 1);
      chk("R4 sleep refused err", req_err_o, 1);
      err_clr = 1;
      go();

      cur_tag = "R7";
      req(3);
      chk("R2 deep mode", mode_o, 3);
      chk("R2 deep sclk", sclk_en_o, 0);
      wake_gen = 1; wake_eth = 1; wake_can = 1;
      go();
      chk("R7 deep ignores wakes", mode_o, 3);
      wake_rtc = 1;
      go();
      chk("R7 rtc to active", mode_o, 1);

      cur_tag = "R6";
      ctl(1, 0, 40);
      req(2);
      wake_gen = 1;
      go();
      chk("R6 bypass clear goes full", mode_o, 0);
      chk("R5 mult on full entry", pll_mult_o, 40);

      cur_tag = "R13";
      req(3);
      wake_rst = 1;
      go();
      chk("R7 reset leaves deep to full", mode_o, 0);
      chk("R13 mult default", pll_mult_o, MD);

      cur_tag = "R8";
      vr_wr = 1; vr_freq = 2'b00; vr_sdram_hold = 1;
      req_vld = 1; req_code = 3'd1;
      go();
      chk("R8 hibernate wins over request", mode_o, 4);
      chk("R2 hibernate supply", vdd_int_en_o, 0);
      chk("R2 hibernate pins", pin_tristate_o, 1);
      chk("R10 hold in hibernate", sdram_cke_low_o, 1);

      cur_tag = "R9";
      wake_gen = 1;
      go();
      chk("R9 wake_gen ignored in hibernate", mode_o, 4);
      wake_can = 1;
      go();
      chk("R9 can starts sequence", mode_o, 5);
      chk("R9 sequence supply on", vdd_int_en_o, 1);
      chk("R9 sequence sclk gated", sclk_en_o, 0);
      chk("R10 hold kept in sequence", sdram_cke_low_o, 1);
      seq_len("R9 sequence length");
      chk("R9 ends in full", mode_o, 0);

      ctl(1, 1, 33);
      vr_wr = 1; vr_freq = 2'b00; vr_sdram_hold = 0;
      go();
      chk("R10 no hold", sdram_cke_low_o, 0);
      wake_eth = 1;
      go();
      seq_len("R9 eth sequence length");
      chk("R9 staged mult discarded", pll_mult_o, MD);

      cur_tag = "R8";
      vr_wr = 1; vr_freq = 2'b10;
      go();
      chk("R8 nonzero field no hibernate", mode_o, 0);

      cur_tag = "R13";
      req(2);
      wake_rst = 1;
      go();
      chk("R13 reset from sleep", mode_o, 0);
      req(5);
      wake_rst = 1;
      go();
      chk("R13 reset clears err", req_err_o, 0);

      cur_tag = "R9";
      vr_wr = 1; vr_freq = 2'b00; vr_sdram_hold = 1;
      go();
      wake_rst = 1;
      go();
      chk("R9 reset starts sequence", mode_o, 5);
      seq_len("R9 rst sequence length");
      chk("R9 back to full", mode_o, 0);

      repeat (2) go();
      finish_run();
   end
endmodule